// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Controller

This block is a bus slave that sits between a simple 32-bit request/ready bus and one serial flash device on a single chip select. The bus reaches two spaces. The register space holds a configuration word, a chip-enable word and a control word for the one chip select. The flash window is where data moves. In pass-through mode the window is a raw pipe: each byte or word written is clocked out on the serial data output, each read clocks bytes in from the serial data input, and chip select follows a software-controlled bit. In the automatic modes a single window access becomes a whole flash command. The controller sends the programmed opcode, then the access address, then an optional dummy byte, then the data. It asserts chip select for that one access only.

The serial side runs in clock mode 0. The clock idles low. Data goes out most significant bit first and is captured on the rising edge. Each half period lasts a fixed number of system clocks, set by a parameter. A bus request is held until the controller raises its ready pulse, and for window accesses that pulse comes only after the serial traffic has finished.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset the configuration and chip-enable words read 0. The control word reads 0x0003_0004: automatic read mode, opcode 0x03, chip-select-stop set. `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: Register space is selected with `bus_win`=0 and decoded on `bus_addr[7:0]`. At 0x00, bit 16 is the window write enable. At 0x04, bit 0 selects 4-byte addressing. At 0x10, bits [1:0] are the mode (0 read, 1 fast read, 2 write, 3 pass-through), bit 2 is chip-select-stop and bits [23:16] are the opcode. Every other bit reads 0.
- R3: The serial clock idles low. Each byte is 8 clock pulses, most significant bit first. `spi_mosi` is stable while `spi_sclk` is high, and `spi_miso` is captured at each rising edge.
- R4: In pass-through mode `spi_cs_n` equals the chip-select-stop bit. A byte write sends `bus_wdata[7:0]`. A word write sends four bytes, bits [31:24] first. Chip select stays low across accesses.
- R5: A pass-through read sends 0x00 bytes. A word read puts the first received byte in [31:24]. A byte read returns the received byte in [7:0] with the upper bits zero.
- R6: A pass-through window access made while chip-select-stop is set is acknowledged with no serial clock.
- R7: In read mode a window read sends the opcode, then address bits [23:0] as three bytes most significant first, then receives 1 or 4 data bytes. Chip select is low for that access only.
- R8: With 4-byte addressing set, the automatic modes send four address bytes, starting with bits [31:24].
- R9: Fast-read mode (mode 1) inserts one 0x00 dummy byte between the address and the data.
- R10: In write mode (mode 2) a window write sends the opcode, the address bytes and then the data bytes (1 or 4, most significant first).
- R11: When configuration bit 16 is 0, every window write is acknowledged with no chip-select activity and no serial clock.
- R12: A window write in read or fast-read mode, or a window read in write mode, is acknowledged with no serial clock. Such a read returns 0.
- R13: `bus_ready` is a one-cycle pulse that ends every access. For an automatic access it comes after the last serial byte, with `spi_cs_n` already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 write, 0 read |
| bus_win | input | 1 | 1 flash window, 0 register space |
| bus_word | input | 1 | 1 32-bit access, 0 byte access |
| bus_addr | input | 32 | Register offset or window address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access-complete pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two events share one cycle at the end of an automatic read. The falling serial clock edge that ends the last data byte is the same cycle in which the final received byte is merged into the read word and chip select is released. The bench checks this at the ready pulse. The returned word must contain the last byte driven by the flash model, and `spi_cs_n` must already be high. In that same cycle the finish pulse must keep a still-held bus request from being taken again. The bench checks this by counting chip-select falls per access: each access must produce exactly one.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } sfc_mode_e;

  localparam logic [7:0]  OFS_CFG    = 8'h00;
  localparam logic [7:0]  OFS_CE     = 8'h04;
  localparam logic [7:0]  OFS_CTRL   = 8'h10;
  localparam int          CFG_WE_BIT = 16;
  localparam logic [7:0]  OP_RESET   = 8'h03;

  // One latched window access
  typedef struct packed {
    logic        auto_m;
    logic        fast;
    logic        four_b;
    logic        word;
    logic        wr;
    logic [7:0]  op;
    logic [31:0] addr;
    logic [31:0] wdata;
  } sfc_acc_t;

  function automatic logic [3:0] addr_len(input logic four_b);
    return four_b ? 4'd4 : 4'd3;
  endfunction

  function automatic logic [3:0] hdr_len(input sfc_acc_t a);
    if (!a.auto_m) return 4'd0;
    return 4'd1 + addr_len(a.four_b) + {3'd0, a.fast};
  endfunction

  function automatic logic [3:0] seq_len(input sfc_acc_t a);
    return hdr_len(a) + (a.word ? 4'd4 : 4'd1);
  endfunction

  // Byte k of the serial sequence for access a
  function automatic logic [7:0] seq_byte(input sfc_acc_t a, input logic [3:0] k);
    logic [3:0] hl;
    logic [3:0] nab;
    int         sh;
    hl  = hdr_len(a);
    nab = addr_len(a.four_b);
    if (a.auto_m && k == 4'd0) return a.op;
    if (a.auto_m && k <= nab) begin
      sh = 8 * (int'(nab) - int'(k));
      return 8'(a.addr >> sh);
    end
    if (k < hl || !a.wr) return 8'h00;
    if (!a.word) return a.wdata[7:0];
    sh = 8 * (3 - int'(k - hl));
    return 8'(a.wdata >> sh);
  endfunction

endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  ofs,
  input  logic [31:0] wdata,
  output logic        cfg_we,
  output logic        four_b,
  output sfc_mode_e   mode,
  output logic        stop,
  output logic [7:0]  op,
  output logic [31:0] rd_val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_we <= 1'b0;
      four_b <= 1'b0;
      mode   <= MODE_READ;
      stop   <= 1'b1;
      op     <= OP_RESET;
    end else if (wr) begin
      case (ofs)
        OFS_CFG:  cfg_we <= wdata[CFG_WE_BIT];
        OFS_CE:   four_b <= wdata[0];
        OFS_CTRL: begin
          mode <= sfc_mode_e'(wdata[1:0]);
          stop <= wdata[2];
          op   <= wdata[23:16];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = 32'h0;
    case (ofs)
      OFS_CFG:  rd_val[CFG_WE_BIT] = cfg_we;
      OFS_CE:   rd_val[0] = four_b;
      OFS_CTRL: rd_val = {8'h00, op, 13'h0, stop, mode};
      default:  rd_val = 32'h0;
    endcase
  end

endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);

  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_CYC - 1);

  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          half_end;

  assign half_end = (div == DIV_LAST);
  assign mosi     = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div  <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx;
          bitn <= '0;
          div  <= '0;
          sclk <= 1'b0;
        end
      end else if (half_end) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end

endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  sfc_acc_t    acc_in,
  input  logic        eng_done,
  input  logic [7:0]  eng_rx,
  output logic        eng_start,
  output logic [7:0]  eng_tx,
  output logic        busy,
  output logic        fin,
  output logic        cs_act,
  output logic [31:0] rdata
);

  sfc_acc_t   acc;
  logic [3:0] k;
  logic       byte_end;
  logic       last_end;
  logic       in_data;

  assign eng_tx   = seq_byte(acc, k);
  assign in_data  = (k >= hdr_len(acc));
  assign byte_end = busy && eng_done;
  assign last_end = byte_end && (k == seq_len(acc) - 4'd1);
  assign cs_act   = busy && acc.auto_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      k         <= '0;
      busy      <= 1'b0;
      fin       <= 1'b0;
      eng_start <= 1'b0;
      rdata     <= '0;
    end else begin
      fin       <= 1'b0;
      eng_start <= 1'b0;
      if (!busy) begin
        if (go) begin
          acc       <= acc_in;
          k         <= '0;
          busy      <= 1'b1;
          eng_start <= 1'b1;
          rdata     <= '0;
        end
      end else if (byte_end) begin
        if (!acc.wr && in_data) rdata <= {rdata[23:0], eng_rx};
        if (last_end) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          k         <= k + 4'd1;
          eng_start <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl
  import sfc_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_win,
  input  logic        bus_word,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  logic        cfg_we, four_b, stop;
  sfc_mode_e   mode;
  logic [7:0]  op;
  logic [31:0] reg_rd;
  logic        user_mode;
  logic        acc_ok, win_acc, reg_acc, reg_wr;
  logic        path_ok, wr_block, shift_go, drop_evt;
  logic        seq_busy, seq_fin, seq_cs;
  logic [31:0] seq_rdata;
  logic        eng_start, eng_done, eng_busy;
  logic [7:0]  eng_tx, eng_rx;
  sfc_acc_t    acc_in;

  assign user_mode = (mode == MODE_USER);
  assign acc_ok    = bus_req && !bus_ready && !seq_busy && !seq_fin;
  assign win_acc   = acc_ok && bus_win;
  assign reg_acc   = acc_ok && !bus_win;
  assign reg_wr    = reg_acc && bus_we;
  assign wr_block  = bus_we && !cfg_we;
  assign path_ok   = user_mode ? !stop
                   : (bus_we ? (mode == MODE_WRITE) : (mode != MODE_WRITE));
  assign shift_go  = win_acc && !wr_block && path_ok;
  assign drop_evt  = win_acc && !shift_go;

  always_comb begin
    acc_in        = '0;
    acc_in.auto_m = !user_mode;
    acc_in.fast   = (mode == MODE_FAST);
    acc_in.four_b = four_b;
    acc_in.word   = bus_word;
    acc_in.wr     = bus_we;
    acc_in.op     = op;
    acc_in.addr   = bus_addr;
    acc_in.wdata  = bus_wdata;
  end

  sfc_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .ofs    (bus_addr[7:0]),
    .wdata  (bus_wdata),
    .cfg_we (cfg_we),
    .four_b (four_b),
    .mode   (mode),
    .stop   (stop),
    .op     (op),
    .rd_val (reg_rd)
  );

  sfc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (shift_go),
    .acc_in    (acc_in),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .busy      (seq_busy),
    .fin       (seq_fin),
    .cs_act    (seq_cs),
    .rdata     (seq_rdata)
  );

  sfc_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .tx    (eng_tx),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .busy  (eng_busy),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  assign spi_cs_n = user_mode ? stop : !seq_cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= reg_acc || drop_evt || seq_fin;
      if (reg_acc)       bus_rdata <= reg_rd;
      else if (drop_evt) bus_rdata <= '0;
      else if (seq_fin)  bus_rdata <= seq_rdata;
    end
  end

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_ready,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic user_mode,
  input logic drop_evt,
  input logic eng_done
);

  assert_sclk_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);

  assert_ready_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  assert_auto_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && !user_mode) |-> spi_cs_n);

  assert_drop_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> bus_ready);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  assert_byte_ends_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> !spi_sclk);

endmodule

bind spi_flash_ctl sfc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ready (bus_ready),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi),
  .user_mode (user_mode),
  .drop_evt  (drop_evt),
  .eng_done  (eng_done)
);

// File: tb/spi_flash_ctl_test.sv
module spi_flash_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0, bus_word = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  spi_flash_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_win(bus_win), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // Flash model: records bytes, returns a counted pattern
  int         nb = 0, bitn = 0, rises = 0, falls = 0;
  logic [7:0] shin = '0;
  logic [7:0] cap [16];

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 37 + 92) & 255);
  endfunction

  always @(negedge spi_cs_n) begin nb = 0; bitn = 0; falls++; end
  always @(posedge spi_sclk) begin
    rises++;
    shin = {shin[6:0], spi_mosi};
    if (bitn == 7) begin cap[nb & 15] = shin; nb++; bitn = 0; end
    else bitn++;
  end
  assign spi_miso = pat(nb)[7 - bitn];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic bus(input logic we, input logic win, input logic word,
                     input logic [31:0] addr, input logic [31:0] wdata,
                     output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_win = win; bus_word = word;
    bus_addr = addr; bus_wdata = wdata;
    forever begin
      @(posedge clk); #1;
      if (bus_ready) break;
    end
    rd = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  logic [31:0] rd;
  logic [7:0]  exq[$];

  task automatic set_ctrl(input logic [7:0] op, input logic stp, input logic [1:0] md);
    logic [31:0] d;
    bus(1'b1, 1'b0, 1'b0, 32'h10, {8'h00, op, 13'h0, stp, md}, d);
  endtask

  task automatic cmp_bytes(input string req);
    chk(req, nb, exq.size());
    foreach (exq[i]) chk(req, cap[i & 15], exq[i]);
  endtask

  task automatic auto_read(input bit fast, input bit fb, input bit word, input logic [31:0] a);
    int f0, hl, nd;
    logic [31:0] er;
    logic [7:0] op;
    op = fast ? 8'h0B : 8'h03;
    bus(1'b1, 1'b0, 1'b0, 32'h04, {31'h0, fb}, rd);
    set_ctrl(op, 1'b1, fast ? 2'd1 : 2'd0);
    f0 = falls;
    bus(1'b0, 1'b1, word, a, 32'h0, rd);
    exq.delete();
    exq.push_back(op);
    for (int i = (fb ? 3 : 2); i >= 0; i--) exq.push_back(8'(a >> (8 * i)));
    if (fast) exq.push_back(8'h00);
    hl = exq.size();
    nd = word ? 4 : 1;
    er = '0;
    for (int i = 0; i < nd; i++) begin exq.push_back(8'h00); er = (er << 8) | 32'(pat(hl + i)); end
    cmp_bytes(fast ? (fb ? "R9 R8" : "R9") : (fb ? "R7 R8" : "R7"));
    chk("R5 R7 read data", rd, er);
    chk("R13 cs released", spi_cs_n, 1'b1);
    chk("R13 one cs per access", falls - f0, 1);
  endtask

  task automatic auto_write(input bit fb, input bit word, input logic [31:0] a);
    logic [31:0] w;
    w = a ^ 32'hA5A5_0F0F;
    bus(1'b1, 1'b0, 1'b0, 32'h04, {31'h0, fb}, rd);
    set_ctrl(8'h02, 1'b1, 2'd2);
    bus(1'b1, 1'b1, word, a, w, rd);
    exq.delete();
    exq.push_back(8'h02);
    for (int i = (fb ? 3 : 2); i >= 0; i--) exq.push_back(8'(a >> (8 * i)));
    if (word) for (int i = 3; i >= 0; i--) exq.push_back(8'(w >> (8 * i)));
    else exq.push_back(w[7:0]);
    cmp_bytes(fb ? "R10 R8" : "R10");
    chk("R13 cs released after write", spi_cs_n, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] addrs [3];
    int r0, f0;
    addrs[0] = 32'h1234_5678; addrs[1] = 32'hFEDC_BA98; addrs[2] = 32'h0000_0001;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cs_n", spi_cs_n, 1'b1);
    chk("R1 sclk", spi_sclk, 1'b0);
    bus(1'b0, 1'b0, 1'b0, 32'h00, 0, rd); chk("R1 cfg", rd, 32'h0);
    bus(1'b0, 1'b0, 1'b0, 32'h04, 0, rd); chk("R1 ce", rd, 32'h0);
    bus(1'b0, 1'b0, 1'b0, 32'h10, 0, rd); chk("R1 ctrl", rd, 32'h0003_0004);

    // R2 field masks
    bus(1'b1, 1'b0, 1'b0, 32'h00, 32'hFFFF_FFFF, rd);
    bus(1'b0, 1'b0, 1'b0, 32'h00, 0, rd); chk("R2 cfg", rd, 32'h0001_0000);
    bus(1'b1, 1'b0, 1'b0, 32'h04, 32'hFFFF_FFFF, rd);
    bus(1'b0, 1'b0, 1'b0, 32'h04, 0, rd); chk("R2 ce", rd, 32'h1);
    bus(1'b1, 1'b0, 1'b0, 32'h10, 32'hFFFF_FFFF, rd);
    bus(1'b0, 1'b0, 1'b0, 32'h10, 0, rd); chk("R2 ctrl", rd, 32'h00FF_0007);
    bus(1'b0, 1'b0, 1'b0, 32'h08, 0, rd); chk("R2 unmapped", rd, 32'h0);

    // Automatic reads: mode x address width x size x address
    for (int fs = 0; fs < 2; fs++)
      for (int fb = 0; fb < 2; fb++)
        for (int wd = 0; wd < 2; wd++)
          for (int ai = 0; ai < 3; ai++)
            auto_read(fs[0], fb[0], wd[0], addrs[ai]);

    // Write mode, enabled
    for (int fb = 0; fb < 2; fb++)
      for (int wd = 0; wd < 2; wd++)
        for (int ai = 0; ai < 3; ai++)
          auto_write(fb[0], wd[0], addrs[ai]);

    // R12 mismatched direction
    r0 = rises;
    bus(1'b0, 1'b1, 1'b1, 32'h100, 0, rd);
    chk("R12 read in write mode data", rd, 32'h0);
    chk("R12 read in write mode clocks", rises - r0, 0);
    set_ctrl(8'h03, 1'b1, 2'd0);
    r0 = rises;
    bus(1'b1, 1'b1, 1'b1, 32'h100, 32'hDEAD_BEEF, rd);
    chk("R12 write in read mode clocks", rises - r0, 0);

    // R11 writes disabled
    bus(1'b1, 1'b0, 1'b0, 32'h00, 32'h0, rd);
    set_ctrl(8'h02, 1'b1, 2'd2);
    r0 = rises; f0 = falls;
    bus(1'b1, 1'b1, 1'b1, 32'h200, 32'h1234_5678, rd);
    chk("R11 no clocks", rises - r0, 0);
    chk("R11 no chip select", falls - f0, 0);

    // Pass-through mode
    set_ctrl(8'h00, 1'b1, 2'd3);
    r0 = rises; f0 = falls;
    bus(1'b1, 1'b1, 1'b0, 0, 32'h9F, rd);
    chk("R11 user write dropped", rises - r0, 0);
    bus(1'b1, 1'b0, 1'b0, 32'h00, 32'h0001_0000, rd);
    r0 = rises;
    bus(1'b0, 1'b1, 1'b1, 0, 0, rd);
    chk("R6 stopped access no clocks", rises - r0, 0);
    chk("R4 cs follows stop=1", spi_cs_n, 1'b1);
    set_ctrl(8'h00, 1'b0, 2'd3);
    chk("R4 cs follows stop=0", spi_cs_n, 1'b0);
    bus(1'b1, 1'b1, 1'b0, 0, 32'hFFFF_FF9F, rd);
    bus(1'b0, 1'b1, 1'b1, 0, 0, rd);
    chk("R5 word read order", rd, {pat(1), pat(2), pat(3), pat(4)});
    bus(1'b1, 1'b1, 1'b1, 0, 32'h1122_3344, rd);
    bus(1'b0, 1'b1, 1'b0, 0, 0, rd);
    chk("R5 byte read", rd, {24'h0, pat(9)});
    chk("R4 cs held low", spi_cs_n, 1'b0);
    exq.delete();
    exq.push_back(8'h9F);
    for (int i = 0; i < 4; i++) exq.push_back(8'h00);
    exq.push_back(8'h11); exq.push_back(8'h22); exq.push_back(8'h33); exq.push_back(8'h44);
    exq.push_back(8'h00);
    cmp_bytes("R4 R5 R3 stream");
    chk("R4 single cs for stream", falls - f0, 1);
    set_ctrl(8'h00, 1'b1, 2'd3);
    chk("R4 cs released by stop", spi_cs_n, 1'b1);
    chk("R3 sclk idle low", spi_sclk, 1'b0);

    finish_run();
  end

endmodule